// File: doc/BRIEF.md
# On-Screen-Display Window Column Sequencer

This block sets the timing of one on-screen-display window that sits inside active video. It runs on the pixel clock. A pixel counter restarts on each rising edge of the horizontal flyback input. A line counter restarts on each rising edge of vertical sync and counts flyback edges. On lines at or below the programmed vertical start, the window opens at a pixel position derived from an 8-bit horizontal code. The window then steps through a programmed number of character columns.

For each window pixel the block reports the character column index and the font pixel index inside that column. Downstream logic uses these two values to fetch glyph data. A 32-bit mask selects the width of each of the first 32 columns. A column with its bit cleared shows each of its 12 font pixels once. A column with its bit set shows each of them twice, so it is 24 pixel clocks wide. All columns past the 32nd are normal width. The start codes, the mask and the column count are captured at vertical sync, so a change takes effect only in the following frame.

Top module: `osd_win_seq`

## Requirements
- R1: While reset is applied and after its release, until the first vertical sync, `in_window` and `cfg_err` are 0 and `col_idx` and `font_px` are 0.
- R2: Pixel 0 is the first clock cycle after the clock edge that sees `hflyback` rise. `in_window` first goes high at pixel `4*hstart_code + 30`, and in that cycle `col_idx` is 0 and `font_px` is 0.
- R3: The line index is the number of `hflyback` rising edges since the last `vsync` rising edge. The window opens only on lines whose index is at least `2*vstart_code`.
- R4: In a column whose mask bit is 0, `font_px` counts 0 to 11, one step per clock, so the column lasts 12 cycles.
- R5: In a column whose mask bit is 1, each `font_px` value from 0 to 11 is held for two consecutive clocks, so the column lasts 24 cycles.
- R6: Bit k of `dbl_mask` sets the width of column k for k from 0 to 31. Columns 32 and above are always 12 cycles wide, whatever the mask holds.
- R7: `col_idx` increments when a column's last pixel ends. `in_window` falls right after the last pixel of column `col_count-1`. With `col_count` 0 the window never opens. Outside the window `col_idx` and `font_px` read 0.
- R8: A horizontal start code of 2 or less, captured at vertical sync, drives `cfg_err` high for the whole frame and keeps the window closed. A legal code clears `cfg_err`.
- R9: `hstart_code`, `vstart_code`, `dbl_mask` and `col_count` are sampled at the clock edge that sees `vsync` rise. A change between syncs has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hflyback | input | 1 | Horizontal flyback pulse; its rising edge starts a line |
| vsync | input | 1 | Vertical sync; its rising edge starts a frame and loads the settings |
| hstart_code | input | 8 | Horizontal start code; the start pixel is code*4+30 |
| vstart_code | input | 8 | Vertical start code; the first window line is code*2 |
| dbl_mask | input | 32 | Double-width select for columns 31 to 0 |
| col_count | input | 6 | Number of character columns in the window |
| in_window | output | 1 | High on every window pixel |
| col_idx | output | 6 | Current character column, 0 outside the window |
| font_px | output | 4 | Font pixel within the column (0 to 11), 0 outside the window |
| cfg_err | output | 1 | Captured horizontal start code is illegal |

## Verification
Every internal fault shows up as a shift in when `in_window` rises or falls, or in the cycle at which `col_idx` steps. A wrong pixel counter or start offset moves the opening edge on the very next line. A wrong width choice or font pixel counter moves every later column boundary, and the error grows toward the end of the window on that same line. Faults in the shadow registers or the line counter appear within one frame: the window opens on the wrong lines, still follows the old settings, or shows the wrong `cfg_err`.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;
  localparam int FONT_PX = 12;
  localparam int FPX_W   = 4;

  // pixel on which the window-open decision is registered (one before start)
  function automatic int open_px(input logic [7:0] code);
    return int'(code) * 4 + 29;
  endfunction
endpackage

// File: rtl/osd_rst_sync.sv
module osd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/osd_hv_timing.sv
module osd_hv_timing
  import osd_seq_pkg::*;
#(
  parameter int HCNT_W = 12,
  parameter int LINE_W = 11,
  parameter int MASK_W = 32,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hfly,
  input  logic              vsync,
  input  logic [7:0]        hcode,
  input  logic [7:0]        vcode,
  input  logic [MASK_W-1:0] mask,
  input  logic [COL_W-1:0]  ncol,
  output logic              hrise,
  output logic [HCNT_W-1:0] hcnt,
  output logic [HCNT_W-1:0] trig,
  output logic              line_ok,
  output logic [MASK_W-1:0] sh_mask,
  output logic [COL_W-1:0]  sh_ncol,
  output logic              cfg_err
);
  localparam logic [HCNT_W-1:0] HMAX = '1;
  localparam logic [LINE_W-1:0] LMAX = '1;

  logic              hfly_q, vs_q, vrise;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [7:0]        shh_q, shh_d, shv_q, shv_d;
  logic [MASK_W-1:0] shm_q, shm_d;
  logic [COL_W-1:0]  shn_q, shn_d;
  logic              err_q, err_d;

  assign hrise = hfly & ~hfly_q;
  assign vrise = vsync & ~vs_q;

  always_comb begin
    hcnt_d = hcnt_q;
    if (hrise)             hcnt_d = '0;
    else if (hcnt_q != HMAX) hcnt_d = hcnt_q + 1'b1;

    line_d = line_q;
    if (vrise)                       line_d = '0;
    else if (hrise && line_q != LMAX) line_d = line_q + 1'b1;

    shh_d = shh_q;
    shv_d = shv_q;
    shm_d = shm_q;
    shn_d = shn_q;
    err_d = err_q;
    if (vrise) begin
      shh_d = hcode;
      shv_d = vcode;
      shm_d = mask;
      shn_d = ncol;
      err_d = (hcode <= 8'd2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hfly_q <= 1'b0;
      vs_q   <= 1'b0;
      hcnt_q <= '0;
      line_q <= '0;
      shh_q  <= '0;
      shv_q  <= '0;
      shm_q  <= '0;
      shn_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      hfly_q <= hfly;
      vs_q   <= vsync;
      hcnt_q <= hcnt_d;
      line_q <= line_d;
      shh_q  <= shh_d;
      shv_q  <= shv_d;
      shm_q  <= shm_d;
      shn_q  <= shn_d;
      err_q  <= err_d;
    end
  end

  assign hcnt    = hcnt_q;
  assign trig    = HCNT_W'(open_px(shh_q));
  assign line_ok = line_q >= LINE_W'({shv_q, 1'b0});
  assign sh_mask = shm_q;
  assign sh_ncol = shn_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/osd_col_seq.sv
module osd_col_seq
  import osd_seq_pkg::*;
#(
  parameter int HCNT_W = 12,
  parameter int MASK_W = 32,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hrise,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [HCNT_W-1:0] trig,
  input  logic              en,
  input  logic [MASK_W-1:0] mask,
  input  logic [COL_W-1:0]  ncol,
  output logic              act,
  output logic [COL_W-1:0]  col,
  output logic [FPX_W-1:0]  fpx,
  output logic              dbl
);
  localparam int MI_W = $clog2(MASK_W);
  localparam logic [FPX_W-1:0] FPX_LAST = FPX_W'(FONT_PX - 1);

  logic             act_q, act_d, done_q, done_d, rep_q, rep_d;
  logic [COL_W-1:0] col_q, col_d, last_col;
  logic [FPX_W-1:0] fpx_q, fpx_d;
  logic [MI_W-1:0]  midx;

  assign midx     = col_q[MI_W-1:0];
  assign dbl      = (col_q < COL_W'(MASK_W)) && mask[midx];
  assign last_col = ncol - 1'b1;

  always_comb begin
    act_d  = act_q;
    done_d = done_q;
    rep_d  = rep_q;
    col_d  = col_q;
    fpx_d  = fpx_q;
    if (hrise) begin
      act_d  = 1'b0;
      done_d = 1'b0;
      rep_d  = 1'b0;
      col_d  = '0;
      fpx_d  = '0;
    end else if (!act_q) begin
      if (!done_q && en && hcnt == trig) act_d = 1'b1;
    end else if (dbl && !rep_q) begin
      rep_d = 1'b1;
    end else begin
      rep_d = 1'b0;
      if (fpx_q == FPX_LAST) begin
        fpx_d = '0;
        if (col_q == last_col) begin
          act_d  = 1'b0;
          done_d = 1'b1;
          col_d  = '0;
        end else begin
          col_d = col_q + 1'b1;
        end
      end else begin
        fpx_d = fpx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b1;
      rep_q  <= 1'b0;
      col_q  <= '0;
      fpx_q  <= '0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      rep_q  <= rep_d;
      col_q  <= col_d;
      fpx_q  <= fpx_d;
    end
  end

  assign act = act_q;
  assign col = col_q;
  assign fpx = fpx_q;
endmodule

// File: rtl/osd_win_seq.sv
module osd_win_seq
  import osd_seq_pkg::*;
#(
  parameter int HCNT_W = 12,
  parameter int LINE_W = 11,
  parameter int MASK_W = 32,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hflyback,
  input  logic              vsync,
  input  logic [7:0]        hstart_code,
  input  logic [7:0]        vstart_code,
  input  logic [MASK_W-1:0] dbl_mask,
  input  logic [COL_W-1:0]  col_count,
  output logic              in_window,
  output logic [COL_W-1:0]  col_idx,
  output logic [FPX_W-1:0]  font_px,
  output logic              cfg_err
);
  logic              rst_sync_n, hrise, line_ok, win_en, dbl_cur;
  logic [HCNT_W-1:0] hcnt, trig;
  logic [MASK_W-1:0] sh_mask;
  logic [COL_W-1:0]  sh_ncol;

  osd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  osd_hv_timing #(
    .HCNT_W (HCNT_W),
    .LINE_W (LINE_W),
    .MASK_W (MASK_W),
    .COL_W  (COL_W)
  ) u_timing (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hfly    (hflyback),
    .vsync   (vsync),
    .hcode   (hstart_code),
    .vcode   (vstart_code),
    .mask    (dbl_mask),
    .ncol    (col_count),
    .hrise   (hrise),
    .hcnt    (hcnt),
    .trig    (trig),
    .line_ok (line_ok),
    .sh_mask (sh_mask),
    .sh_ncol (sh_ncol),
    .cfg_err (cfg_err)
  );

  assign win_en = line_ok && !cfg_err && (sh_ncol != '0);

  osd_col_seq #(
    .HCNT_W (HCNT_W),
    .MASK_W (MASK_W),
    .COL_W  (COL_W)
  ) u_cols (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hrise (hrise),
    .hcnt  (hcnt),
    .trig  (trig),
    .en    (win_en),
    .mask  (sh_mask),
    .ncol  (sh_ncol),
    .act   (in_window),
    .col   (col_idx),
    .fpx   (font_px),
    .dbl   (dbl_cur)
  );
endmodule

// File: rtl/osd_win_seq_chk.sv
module osd_win_seq_chk #(
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hrise,
  input logic             in_window,
  input logic [COL_W-1:0] col_idx,
  input logic [3:0]       font_px,
  input logic             cfg_err,
  input logic             dbl_cur,
  input logic [COL_W-1:0] sh_ncol
);
  // R4
  font_px_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> font_px <= 4'd11);

  // R8
  err_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !in_window);

  // R2
  open_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_window) |-> (col_idx == '0 && font_px == 4'd0));

  // R4
  normal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && $past(in_window) && !dbl_cur && col_idx == $past(col_idx))
      |-> font_px == $past(font_px) + 4'd1);

  // R7
  close_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_window) && !$past(hrise))
      |-> ($past(font_px) == 4'd11 && $past(col_idx) + 1'b1 == $past(sh_ncol)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (col_idx == '0 && font_px == 4'd0));
endmodule

bind osd_win_seq osd_win_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hrise     (hrise),
  .in_window (in_window),
  .col_idx   (col_idx),
  .font_px   (font_px),
  .cfg_err   (cfg_err),
  .dbl_cur   (dbl_cur),
  .sh_ncol   (sh_ncol)
);

// File: tb/osd_win_seq_bench.sv
module osd_win_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hflyback, vsync;
  logic [7:0]  hstart_code, vstart_code;
  logic [31:0] dbl_mask;
  logic [5:0]  col_count;
  logic        in_window, cfg_err;
  logic [5:0]  col_idx;
  logic [3:0]  font_px;

  int checks = 0;
  int fails  = 0;

  // captured frame settings and the current line index, as the bench sees them
  int          e_s, e_v, e_ncol, e_line;
  bit          e_err;
  logic [31:0] e_mask;

  always #10 clk = ~clk;

  osd_win_seq u_osd_win_seq (
    .clk(clk), .rst_n(rst_n), .hflyback(hflyback), .vsync(vsync),
    .hstart_code(hstart_code), .vstart_code(vstart_code),
    .dbl_mask(dbl_mask), .col_count(col_count),
    .in_window(in_window), .col_idx(col_idx), .font_px(font_px),
    .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void expect_px(input int p, output bit a, output int c,
                                    output int f);
    int off, w;
    a = 0; c = 0; f = 0;
    if (e_err || e_ncol == 0 || e_line < 2 * e_v) return;
    off = p - e_s;
    if (off < 0) return;
    for (int k = 0; k < e_ncol; k++) begin
      w = (k < 32 && e_mask[k]) ? 24 : 12;
      if (off < w) begin
        a = 1; c = k; f = (w == 24) ? off / 2 : off;
        return;
      end
      off -= w;
    end
  endfunction

  task automatic do_vsync();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    e_s    = int'(hstart_code) * 4 + 30;
    e_v    = int'(vstart_code);
    e_mask = dbl_mask;
    e_ncol = int'(col_count);
    e_err  = (hstart_code <= 8'd2);
    e_line = 0;
  endtask

  // one scan line; every pixel is compared, counted as one check per line
  task automatic run_line(input string tag);
    bit a; int c, f, len, bad_p;
    bit bad;
    len = e_s + e_ncol * 24 + 8;
    bad = 0; bad_p = 0;
    @(negedge clk) hflyback = 1'b1;
    e_line++;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      if (p == 0) hflyback = 1'b0;
      expect_px(p, a, c, f);
      if (!bad && (in_window !== a || int'(col_idx) != c || int'(font_px) != f)) begin
        bad = 1; bad_p = p;
        $display("FAIL %s line %0d pixel %0d: win/col/px actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                 tag, e_line, p, in_window, col_idx, font_px, a, c, f);
      end
    end
    checks++;
    if (bad) fails++;
  endtask

  task automatic set_cfg(input int h, input int v, input logic [31:0] m,
                         input int n);
    hstart_code = 8'(h); vstart_code = 8'(v); dbl_mask = m; col_count = 6'(n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hflyback = 1'b0; vsync = 1'b0;
    set_cfg(10, 0, 32'hFFFF_FFFF, 8);
    e_s = 0; e_v = 0; e_ncol = 0; e_line = 0; e_err = 0; e_mask = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check(in_window == 0 && col_idx == 0 && font_px == 0, "R1", "win in reset",
          in_window, 0);
    check(cfg_err == 0, "R1", "cfg_err in reset", cfg_err, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: no window before first sync even with flyback (shadow column count 0)
    run_line("R1");

    // R2 R6: minimum legal code, all-double mask, columns past 32 normal width
    set_cfg(3, 0, 32'hFFFF_FFFF, 34);
    do_vsync();
    check(cfg_err == 0, "R8", "cfg_err legal", cfg_err, 0);
    repeat (2) run_line("R6");

    // R4 R3: normal width, window from line 4
    set_cfg(7, 2, 32'h0, 5);
    do_vsync();
    for (int l = 0; l < 5; l++) run_line("R3");

    // R5 R9: alternating mask, then a mid-frame write that must not apply
    set_cfg(20, 0, 32'h5555_5555, 6);
    do_vsync();
    run_line("R5");
    set_cfg(40, 1, 32'hAAAA_AAAA, 3);
    repeat (2) run_line("R9");
    do_vsync();
    run_line("R9");

    // R8: illegal codes 2 and 0
    set_cfg(2, 0, 32'h0, 4);
    do_vsync();
    check(cfg_err == 1, "R8", "cfg_err code 2", cfg_err, 1);
    run_line("R8");
    set_cfg(0, 0, 32'h0, 4);
    do_vsync();
    check(cfg_err == 1, "R8", "cfg_err code 0", cfg_err, 1);
    run_line("R8");

    // R7: zero columns never opens, one column opens and closes
    set_cfg(9, 0, 32'h0, 0);
    do_vsync();
    run_line("R7");
    set_cfg(9, 0, 32'h1, 1);
    do_vsync();
    run_line("R7");
    set_cfg(9, 0, 32'h0, 63);
    do_vsync();
    run_line("R7");

    // constrained random frames
    void'($urandom(32'd1253));
    for (int fr = 0; fr < 6; fr++) begin
      set_cfg(3 + int'($urandom_range(57)), int'($urandom_range(2)), $urandom(),
              1 + int'($urandom_range(39)));
      do_vsync();
      for (int l = 0; l < 5; l++) run_line("R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule